// File: doc/BRIEF.md
# Flash Write-Status Polling Responder

This block models the read path of a parallel NOR-style flash while it runs its internal program and erase jobs. A host issues program, erase, erase-suspend and erase-resume commands on a one-cycle command strobe. A per-sector protection map comes with each command. The block holds a small word-addressed register file that stands in for the cell array. On every read it returns either the stored word or a status byte. Only the top bit of the status byte carries meaning; the lower bits read as zero.

A host polls the status byte to learn when a job has finished. During a program job, the top bit is the inverse of the top bit of the word being written. It turns true once the write lands. During an erase job, it reads 0 and turns 1 when the erase finishes or is suspended. Jobs that target only protected sectors show busy status for a short fixed window and leave the array untouched. All durations are counted in clock cycles and set by parameters.

The sector of an address is its top SECT_W bits. Command codes on `cmd_op` are: 0 = resume, 1 = program, 2 = erase, 3 = suspend.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, no job is active and a read of word address a returns (3*a + 1) mod 256.
- R2: An accepted program to an unprotected sector makes a read at the program address return {~D[7], 7'b0} for exactly PROG_CYC cycles, starting the cycle after the accepting edge. After that, the read returns the programmed word D.
- R3: While a job runs, reads at addresses outside its status target return the current array contents.
- R4: A program aimed at a protected sector shows the R2 status for exactly PPROT_CYC cycles and then leaves the word unchanged.
- R5: An erase whose selected sectors include at least one unprotected sector reads 8'h00 in every selected sector for ERASE_CYC active cycles. Afterwards the unprotected selected sectors read 8'hFF and the protected ones keep their contents.
- R6: An erase in which no selected sector is unprotected reads 8'h00 in the selected sectors for exactly EPROT_CYC cycles, then returns array data with the array unchanged.
- R7: A suspend (code 3) during an erase makes the selected sectors read 8'h80 and freezes the remaining erase time. A resume (code 0) continues the erase for exactly the cycles that were left.
- R8: While suspended, a program to a sector not being erased runs as in R2 or R4 and then returns to the suspended state. A program to a sector being erased is ignored.
- R9: A command is ignored while a program or protected window is busy. During an erase only suspend is accepted. During suspend an erase is ignored, and a suspend with no erase running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Command code: 0 resume, 1 program, 2 erase, 3 suspend |
| cmd_addr | input | ADDR_W | Program word address |
| cmd_data | input | DATA_W | Program datum |
| cmd_sectors | input | 2**SECT_W | Erase sector selection, one bit per sector |
| prot_map | input | 2**SECT_W | Sector protection, sampled when a command is accepted |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Array word or status byte, combinational from rd_addr |

## Verification
A wrong job state shows up in the read port on the first cycle after the accepting edge. The bench therefore samples the status byte on every cycle of each busy window, not only at its ends. A window that is one cycle short or long, or a remaining erase time that was not frozen during suspend, changes the read value at the exact expected boundary cycle. A wrong write mask or an accepted command that should have been ignored remains in the array and is seen by the next read of the affected address.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    OP_RESUME  = 2'd0,
    OP_PROGRAM = 2'd1,
    OP_ERASE   = 2'd2,
    OP_SUSPEND = 2'd3
  } fps_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_PPROT,
    ST_ERASE,
    ST_EPROT,
    ST_SUSP
  } fps_state_e;
endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (load)                 count <= load_val;
    else if (en && count != '0)    count <= count - 1'b1;
  end

  assign last = (count == CNT_W'(1));
endmodule

// File: rtl/fps_array.sv
module fps_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              erase_we,
  input  logic [NSECT-1:0]  erase_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [DATA_W-1:0] init_word(input int a);
    return DATA_W'(a * 3 + 1);
  endfunction

  function automatic logic [SECT_W-1:0] sector_of(input int a);
    logic [ADDR_W-1:0] aw;
    aw = ADDR_W'(a);
    return aw[ADDR_W-1 -: SECT_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= init_word(a);
    end else begin
      if (erase_we) begin
        for (int a = 0; a < DEPTH; a++)
          if (erase_mask[sector_of(a)]) mem[a] <= '1;
      end
      if (prog_we) mem[prog_addr] <= prog_data;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SECT_W    = 2,
  parameter int CNT_W     = 5,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20,
  parameter int PPROT_CYC = 3,
  parameter int EPROT_CYC = 10,
  localparam int NSECT    = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [NSECT-1:0]  cmd_sectors,
  input  logic [NSECT-1:0]  prot_map,
  output fps_state_e        st,
  output logic [ADDR_W-1:0] paddr_q,
  output logic [DATA_W-1:0] pdata_q,
  output logic [NSECT-1:0]  esel_q,
  output logic [NSECT-1:0]  emask_q,
  output logic              susp_bg,
  output logic              prog_done,
  output logic              erase_done,
  output logic [CNT_W-1:0]  op_cnt,
  output logic [CNT_W-1:0]  er_cnt
);
  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  fps_op_e          op;
  fps_state_e       st_n;
  logic             prot_hit, in_esel, no_target;
  logic [NSECT-1:0] emask_n;
  logic             acc_prog, acc_erase, acc_susp, acc_resume;
  logic             op_load, op_en, op_last, er_load, er_en, er_last;
  logic [CNT_W-1:0] op_val;

  assign op        = fps_op_e'(cmd_op);
  assign prot_hit  = prot_map[sector_of(cmd_addr)];
  assign in_esel   = esel_q[sector_of(cmd_addr)];
  assign emask_n   = cmd_sectors & ~prot_map;
  assign no_target = (emask_n == '0);

  assign acc_prog   = cmd_valid && op == OP_PROGRAM &&
                      (st == ST_IDLE || (st == ST_SUSP && !in_esel));
  assign acc_erase  = cmd_valid && op == OP_ERASE   && st == ST_IDLE;
  assign acc_susp   = cmd_valid && op == OP_SUSPEND && st == ST_ERASE && !er_last;
  assign acc_resume = cmd_valid && op == OP_RESUME  && st == ST_SUSP;

  assign op_load = acc_prog || (acc_erase && no_target);
  assign op_val  = acc_prog ? (prot_hit ? CNT_W'(PPROT_CYC) : CNT_W'(PROG_CYC))
                            : CNT_W'(EPROT_CYC);
  assign op_en   = (st == ST_PROG) || (st == ST_PPROT) || (st == ST_EPROT);
  assign er_load = acc_erase && !no_target;
  assign er_en   = (st == ST_ERASE);

  fps_timer #(.CNT_W(CNT_W)) u_op_tmr (
    .clk(clk), .rst_n(rst_n), .load(op_load), .load_val(op_val),
    .en(op_en), .count(op_cnt), .last(op_last)
  );

  fps_timer #(.CNT_W(CNT_W)) u_er_tmr (
    .clk(clk), .rst_n(rst_n), .load(er_load), .load_val(CNT_W'(ERASE_CYC)),
    .en(er_en), .count(er_cnt), .last(er_last)
  );

  assign prog_done  = (st == ST_PROG)  && op_last;
  assign erase_done = (st == ST_ERASE) && er_last;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: begin
        if (acc_prog)       st_n = prot_hit ? ST_PPROT : ST_PROG;
        else if (acc_erase) st_n = no_target ? ST_EPROT : ST_ERASE;
      end
      ST_PROG, ST_PPROT: if (op_last) st_n = susp_bg ? ST_SUSP : ST_IDLE;
      ST_EPROT:          if (op_last) st_n = ST_IDLE;
      ST_ERASE: begin
        if (er_last)       st_n = ST_IDLE;
        else if (acc_susp) st_n = ST_SUSP;
      end
      ST_SUSP: begin
        if (acc_prog)        st_n = prot_hit ? ST_PPROT : ST_PROG;
        else if (acc_resume) st_n = ST_ERASE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      paddr_q <= '0;
      pdata_q <= '0;
      esel_q  <= '0;
      emask_q <= '0;
      susp_bg <= 1'b0;
    end else begin
      st <= st_n;
      if (acc_prog) begin
        paddr_q <= cmd_addr;
        pdata_q <= cmd_data;
      end
      if (acc_erase) begin
        esel_q  <= cmd_sectors;
        emask_q <= emask_n;
      end
      if (acc_prog && st == ST_SUSP)                        susp_bg <= 1'b1;
      else if ((st == ST_PROG || st == ST_PPROT) && op_last) susp_bg <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20,
  parameter int PPROT_CYC = 3,
  parameter int EPROT_CYC = 10,
  localparam int NSECT    = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [NSECT-1:0]  cmd_sectors,
  input  logic [NSECT-1:0]  prot_map,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int MAX_PE = (PROG_CYC  > ERASE_CYC) ? PROG_CYC  : ERASE_CYC;
  localparam int MAX_PP = (PPROT_CYC > EPROT_CYC) ? PPROT_CYC : EPROT_CYC;
  localparam int MAX_C  = (MAX_PE > MAX_PP) ? MAX_PE : MAX_PP;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  function automatic logic [DATA_W-1:0] status_word(input logic b7);
    return {b7, {(DATA_W-1){1'b0}}};
  endfunction

  fps_state_e        st;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q, arr_word;
  logic [NSECT-1:0]  esel_q, emask_q;
  logic              susp_bg, prog_done, erase_done;
  logic [CNT_W-1:0]  op_cnt, er_cnt;
  logic              prog_vis, erase_vis, susp_vis, rd_in_esel;

  fps_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .PPROT_CYC(PPROT_CYC), .EPROT_CYC(EPROT_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sectors(cmd_sectors),
    .prot_map(prot_map), .st(st), .paddr_q(paddr_q), .pdata_q(pdata_q),
    .esel_q(esel_q), .emask_q(emask_q), .susp_bg(susp_bg),
    .prog_done(prog_done), .erase_done(erase_done),
    .op_cnt(op_cnt), .er_cnt(er_cnt)
  );

  fps_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_done), .prog_addr(paddr_q), .prog_data(pdata_q),
    .erase_we(erase_done), .erase_mask(emask_q),
    .rd_addr(rd_addr), .rd_word(arr_word)
  );

  assign prog_vis   = (st == ST_PROG)  || (st == ST_PPROT);
  assign erase_vis  = (st == ST_ERASE) || (st == ST_EPROT);
  assign susp_vis   = (st == ST_SUSP)  || susp_bg;
  assign rd_in_esel = esel_q[rd_addr[ADDR_W-1 -: SECT_W]];

  always_comb begin
    if (prog_vis && rd_addr == paddr_q) rd_data = status_word(~pdata_q[DATA_W-1]);
    else if (erase_vis && rd_in_esel)   rd_data = status_word(1'b0);
    else if (susp_vis && rd_in_esel)    rd_data = status_word(1'b1);
    else                                rd_data = arr_word;
  end
endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int PPROT_CYC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input fps_state_e       st,
  input logic             prog_done,
  input logic             erase_done,
  input logic             susp_bg,
  input logic [CNT_W-1:0] op_cnt,
  input logic [CNT_W-1:0] er_cnt
);
  a_r7_time_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP) |=> (er_cnt == $past(er_cnt)));

  a_r4_no_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PPROT || st == ST_EPROT) |-> (!prog_done && !erase_done));

  a_r4_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PPROT) |-> (op_cnt != '0 && op_cnt <= CNT_W'(PPROT_CYC)));

  a_r2_prog_exit: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (st == ST_IDLE || st == ST_SUSP));

  a_r5_erase_exit: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> (st == ST_IDLE));

  a_r6_eprot_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EPROT) |=> (st == ST_EPROT || st == ST_IDLE));

  a_r8_bg_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    susp_bg |-> (st == ST_PROG || st == ST_PPROT));
endmodule

bind flash_poll_status fps_checker #(.CNT_W(CNT_W), .PPROT_CYC(PPROT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .prog_done(prog_done),
  .erase_done(erase_done), .susp_bg(susp_bg), .op_cnt(op_cnt), .er_cnt(er_cnt)
);

// File: tb/sim_flash_poll_status.sv
`timescale 1ns/100ps
module sim_flash_poll_status;
  localparam int PROG_N = 6, ERASE_N = 20, PPROT_N = 3, EPROT_N = 10;
  localparam logic [1:0] C_RES = 2'd0, C_PRG = 2'd1, C_ERS = 2'd2, C_SUS = 2'd3;

  logic       clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [5:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0, rd_data;
  logic [3:0] cmd_sectors = '0, prot_map = '0;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [7:0] model [64];

  always #2 clk = ~clk;

  flash_poll_status u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sectors(cmd_sectors),
    .prot_map(prot_map), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [5:0] addr;
    logic [7:0] data;
    logic [3:0] sel;
    logic [3:0] prot;
    logic [5:0] probe;
    logic [5:0] other;
    logic [7:0] cyc;
    logic [7:0] stat;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{C_PRG, 6'h05, 8'h3C, 4'h0, 4'h0, 6'h05, 6'h06, 8'(PROG_N),  8'h80},
    '{C_PRG, 6'h12, 8'hA7, 4'h0, 4'h0, 6'h12, 6'h13, 8'(PROG_N),  8'h00},
    '{C_PRG, 6'h23, 8'h11, 4'h0, 4'h4, 6'h23, 6'h24, 8'(PPROT_N), 8'h80},
    '{C_ERS, 6'h00, 8'h00, 4'h3, 4'h2, 6'h02, 6'h12, 8'(ERASE_N), 8'h00},
    '{C_ERS, 6'h00, 8'h00, 4'hC, 4'hC, 6'h30, 6'h23, 8'(EPROT_N), 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #0.5;
    check(req, rd_data, exp);
  endtask

  task automatic issue(input logic [1:0] op, input logic [5:0] a,
                       input logic [7:0] d, input logic [3:0] s);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sectors = s; cmd_valid = 1'b1;
    @(posedge clk);
    #0.5 cmd_valid = 1'b0;
  endtask

  task automatic model_erase(input logic [3:0] mask);
    for (int a = 0; a < 64; a++)
      if (mask[a / 16]) model[a] = 8'hFF;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int a = 0; a < 64; a++) model[a] = 8'(a + a + a + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents and no status anywhere
    rd_chk("R1", 6'h00, 8'h01);
    rd_chk("R1", 6'h3F, 8'hBE);
    rd_chk("R1", 6'h25, model[6'h25]);

    // Vector walk: R2, R4, R5, R6
    for (int i = 0; i < 5; i++) begin
      vec_t v = VECS[i];
      prot_map = v.prot;
      issue(v.op, v.addr, v.data, v.sel);
      for (int j = 0; j < int'(v.cyc); j++) rd_chk("R2/R4/R5/R6 window", v.probe, v.stat);
      if (v.op == C_PRG && !v.prot[v.addr[5:4]]) model[v.addr] = v.data;
      if (v.op == C_ERS) model_erase(v.sel & ~v.prot);
      rd_chk("R2/R4/R5/R6 after", v.probe, model[v.probe]);
      rd_chk("R4/R5/R6 untouched", v.other, model[v.other]);
    end
    prot_map = 4'h0;

    // R3: other addresses read array during a program
    issue(C_PRG, 6'h08, 8'h55, 4'h0);
    rd_chk("R3", 6'h09, model[6'h09]);
    rd_chk("R2", 6'h08, 8'h80);
    repeat (4) @(negedge clk);
    model[6'h08] = 8'h55;
    rd_chk("R2", 6'h08, 8'h55);

    // R9: second program while busy is dropped
    issue(C_PRG, 6'h0A, 8'h91, 4'h0);
    issue(C_PRG, 6'h0B, 8'h42, 4'h0);
    rd_chk("R9", 6'h0A, 8'h00);
    repeat (4) @(negedge clk);
    model[6'h0A] = 8'h91;
    rd_chk("R9", 6'h0A, 8'h91);
    rd_chk("R9", 6'h0B, model[6'h0B]);

    // R9: suspend with no erase running has no effect
    issue(C_SUS, 6'h00, 8'h00, 4'h0);
    rd_chk("R9", 6'h21, model[6'h21]);

    // R7 / R8: suspend, program in suspend, resume
    issue(C_ERS, 6'h00, 8'h00, 4'h4);
    rd_chk("R5", 6'h25, 8'h00);
    repeat (4) @(negedge clk);
    issue(C_SUS, 6'h00, 8'h00, 4'h0);
    rd_chk("R7", 6'h25, 8'h80);
    rd_chk("R7", 6'h05, model[6'h05]);
    issue(C_ERS, 6'h00, 8'h00, 4'h1);
    rd_chk("R9", 6'h05, model[6'h05]);
    rd_chk("R9", 6'h25, 8'h80);
    issue(C_PRG, 6'h31, 8'hC3, 4'h0);
    rd_chk("R8", 6'h31, 8'h00);
    rd_chk("R8", 6'h26, 8'h80);
    repeat (4) @(negedge clk);
    model[6'h31] = 8'hC3;
    rd_chk("R8", 6'h31, 8'hC3);
    rd_chk("R8", 6'h27, 8'h80);
    issue(C_PRG, 6'h22, 8'h80, 4'h0);
    rd_chk("R8", 6'h22, 8'h80);
    rd_chk("R8", 6'h22, 8'h80);
    issue(C_RES, 6'h00, 8'h00, 4'h0);
    for (int j = 0; j < ERASE_N - 6; j++) rd_chk("R7 resumed", 6'h2A, 8'h00);
    model_erase(4'h4);
    rd_chk("R7", 6'h2A, 8'hFF);
    rd_chk("R8", 6'h22, 8'hFF);
    rd_chk("R8", 6'h31, model[6'h31]);

    summary();
  end
endmodule